// File: doc/BRIEF.md
# Branch Condition and Flag Unit

This block keeps the processor's flag register and a second, identically built 16-bit test register. Either register can have one bit set or cleared by a 4-bit index in a single instruction, with no mask and no read-modify-write through the arithmetic unit. The same block evaluates every conditional branch and the two direct jumps. It tests a selected flag or test bit, checks a counter against zero, or compares two register values as unsigned numbers. It then reports whether the branch is taken and which program counter follows.

The program counter is 24 bits wide. A local target is 16 bits and replaces only the low half of the counter, so the upper 8 sector bits are kept. The global jump loads all 24 bits. For the two count-down branches the block also supplies the decremented counter value and a write strobe, which is raised only when the branch falls through. The compare and count-down branches update the carry, zero and negative flags. Branch evaluation is combinational within the instruction's cycle. Register updates land on the next clock edge, so a test in the cycle of a set or clear sees the old value.

Top module: `bfu_top`

## Requirements
- R1: After reset, `flags` and `testBits` are all zero; with `opValid` low, `taken` and `decWrite` are 0 and `pcNext` equals `pcIn`.
- R2: Opcode 0xE0 sets and 0xE1 clears bit `sel` of `flags` at the next clock edge. No other bit of `flags` changes, and `testBits` does not change.
- R3: Opcode 0xE2 sets and 0xE3 clears bit `sel` of `testBits` at the next clock edge. No other bit of `testBits` changes, and `flags` does not change.
- R4: Opcode 0x80 is taken when `flags[sel]` is 1 and 0x81 when it is 0. Opcode 0x82 is taken when `testBits[sel]` is 1 and 0x83 when it is 0.
- R5: Opcode 0x84 is taken when `regA` is zero and 0x85 when `regA` is non-zero. For either opcode, when not taken, `decWrite` is 1 and `decValue` equals `regA - 1` modulo 2^16. Otherwise `decWrite` is 0.
- R6: Opcodes 0x86, 0x87, 0x88 and 0x89 are taken when `regA` is equal to, not equal to, greater than, or greater than or equal to `regB`. The comparisons are unsigned.
- R7: Opcodes 0x86 to 0x89 write carry, zero and negative into `flags` bits 0, 1 and 2 at the next edge, taken from `regA - regB`. Carry is the borrow (regA < regB unsigned), zero means the difference is 0, and negative is bit 15 of the difference. Opcodes 0x84 and 0x85 do the same from `regA - 1`. Bits 3 to 15 and `testBits` are left unchanged.
- R8: A taken branch (0x80 to 0x89) or opcode 0xC0, which is always taken, gives `pcNext = {pcIn[23:16], target}`.
- R9: Opcode 0xC1 is always taken and gives `pcNext = {targetHigh, target}`.
- R10: A conditional branch that is not taken gives `pcNext = pcIn + 2` modulo 2^24, so carries reach the sector bits. Any other opcode with `opValid` high gives `taken = 0` and `pcNext = pcIn + 1`, and changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Instruction opcode |
| sel | input | 4 | Flag or test bit index |
| regA | input | 16 | First operand (counter or left compare value) |
| regB | input | 16 | Second compare operand |
| target | input | 16 | Low 16 bits of the target address |
| targetHigh | input | 8 | Upper 8 bits of a global target |
| pcIn | input | 24 | Address of the current instruction |
| taken | output | 1 | Branch or jump is taken |
| pcNext | output | 24 | Following program counter |
| decWrite | output | 1 | Write `decValue` back to the counter register |
| decValue | output | 16 | Counter minus one |
| flags | output | 16 | Flag register |
| testBits | output | 16 | Test register |

## Verification
The hardest case to reach from the ports is a fall-through that carries out of the low 16 bits into the sector bits. Random program counters almost never land at 0xFFFE or 0xFFFF in the low half, so the bench drives such addresses directly, including the 24-bit wrap. Equal operands and a counter of exactly 0 or 1 are just as rare under random stimulus. The bench therefore draws operands from a small pool of edge values, which lets the equal, zero and borrow flags flip. Random set and clear operations run alongside the flag tests, so the tests act on bit patterns the bench itself has built up.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;

  localparam logic [7:0] OP_BR_FLAG   = 8'h80;
  localparam logic [7:0] OP_BR_NFLAG  = 8'h81;
  localparam logic [7:0] OP_BR_BIT    = 8'h82;
  localparam logic [7:0] OP_BR_NBIT   = 8'h83;
  localparam logic [7:0] OP_BR_ZDEC   = 8'h84;
  localparam logic [7:0] OP_BR_NZDEC  = 8'h85;
  localparam logic [7:0] OP_BR_EQ     = 8'h86;
  localparam logic [7:0] OP_BR_NE     = 8'h87;
  localparam logic [7:0] OP_BR_GT     = 8'h88;
  localparam logic [7:0] OP_BR_GE     = 8'h89;
  localparam logic [7:0] OP_JMP_LOCAL = 8'hC0;
  localparam logic [7:0] OP_JMP_GLOB  = 8'hC1;
  localparam logic [7:0] OP_SET_FLAG  = 8'hE0;
  localparam logic [7:0] OP_CLR_FLAG  = 8'hE1;
  localparam logic [7:0] OP_SET_TBIT  = 8'hE2;
  localparam logic [7:0] OP_CLR_TBIT  = 8'hE3;

  typedef enum logic [2:0] {
    COND_NONE, COND_ALWAYS, COND_FLAG, COND_TBIT,
    COND_ZERO, COND_EQ, COND_GT, COND_GE
  } cond_e;

  typedef struct packed {
    logic       isBranch;
    cond_e      cond;
    logic       invert;
    logic       globalTgt;
    logic [1:0] insnLen;
    logic       countDown;
    logic       cznUpdate;
    logic       cznFromDec;
    logic       bitWrite;
    logic       bitToTest;
    logic       bitValue;
  } ctrl_t;

endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic       opValid,
  input  logic [7:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    if (opValid) begin
      ctrl.insnLen = 2'd1;
      unique case (opcode)
        OP_BR_FLAG, OP_BR_NFLAG: begin
          ctrl.isBranch = 1'b1; ctrl.insnLen = 2'd2;
          ctrl.cond = COND_FLAG; ctrl.invert = opcode[0];
        end
        OP_BR_BIT, OP_BR_NBIT: begin
          ctrl.isBranch = 1'b1; ctrl.insnLen = 2'd2;
          ctrl.cond = COND_TBIT; ctrl.invert = opcode[0];
        end
        OP_BR_ZDEC, OP_BR_NZDEC: begin
          ctrl.isBranch = 1'b1; ctrl.insnLen = 2'd2;
          ctrl.cond = COND_ZERO; ctrl.invert = opcode[0];
          ctrl.countDown = 1'b1;
          ctrl.cznUpdate = 1'b1; ctrl.cznFromDec = 1'b1;
        end
        OP_BR_EQ, OP_BR_NE: begin
          ctrl.isBranch = 1'b1; ctrl.insnLen = 2'd2;
          ctrl.cond = COND_EQ; ctrl.invert = opcode[0];
          ctrl.cznUpdate = 1'b1;
        end
        OP_BR_GT: begin
          ctrl.isBranch = 1'b1; ctrl.insnLen = 2'd2;
          ctrl.cond = COND_GT; ctrl.cznUpdate = 1'b1;
        end
        OP_BR_GE: begin
          ctrl.isBranch = 1'b1; ctrl.insnLen = 2'd2;
          ctrl.cond = COND_GE; ctrl.cznUpdate = 1'b1;
        end
        OP_JMP_LOCAL: begin
          ctrl.isBranch = 1'b1; ctrl.insnLen = 2'd2;
          ctrl.cond = COND_ALWAYS;
        end
        OP_JMP_GLOB: begin
          ctrl.isBranch = 1'b1; ctrl.insnLen = 2'd3;
          ctrl.cond = COND_ALWAYS; ctrl.globalTgt = 1'b1;
        end
        OP_SET_FLAG, OP_CLR_FLAG, OP_SET_TBIT, OP_CLR_TBIT: begin
          ctrl.bitWrite  = 1'b1;
          ctrl.bitToTest = opcode[1];
          ctrl.bitValue  = ~opcode[0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 24,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int HI_W  = PC_W - DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] target,
  input  logic [HI_W-1:0]   targetHigh,
  input  logic [PC_W-1:0]   pcIn,
  output logic              taken,
  output logic [PC_W-1:0]   pcNext,
  output logic              decWrite,
  output logic [DATA_W-1:0] decValue,
  output logic [DATA_W-1:0] flagReg,
  output logic [DATA_W-1:0] testReg
);

  // One bit-replace path, used by both registers alike.
  function automatic logic [DATA_W-1:0] applyBit(
    input logic [DATA_W-1:0] cur, input logic en,
    input logic [SEL_W-1:0] idx, input logic val);
    logic [DATA_W-1:0] res;
    res = cur;
    if (en) res[idx] = val;
    return res;
  endfunction

  logic [DATA_W:0]   diffAB;
  logic              borrowAB, eqAB, condRaw;
  logic              cznC, cznZ, cznN;
  logic [DATA_W-1:0] flagBase, flagNext, testNext;

  assign diffAB   = {1'b0, regA} - {1'b0, regB};
  assign borrowAB = diffAB[DATA_W];
  assign eqAB     = (diffAB[DATA_W-1:0] == '0);
  assign decValue = regA - DATA_W'(1);

  always_comb begin
    unique case (ctrl.cond)
      COND_NONE:   condRaw = 1'b0;
      COND_ALWAYS: condRaw = 1'b1;
      COND_FLAG:   condRaw = flagReg[sel];
      COND_TBIT:   condRaw = testReg[sel];
      COND_ZERO:   condRaw = (regA == '0);
      COND_EQ:     condRaw = eqAB;
      COND_GT:     condRaw = !borrowAB && !eqAB;
      COND_GE:     condRaw = !borrowAB;
    endcase
  end

  assign taken    = ctrl.isBranch & (condRaw ^ ctrl.invert);
  assign decWrite = ctrl.countDown & ~taken;

  always_comb begin
    if (taken)
      pcNext = ctrl.globalTgt ? {targetHigh, target} : {pcIn[PC_W-1:DATA_W], target};
    else
      pcNext = pcIn + PC_W'(ctrl.insnLen);
  end

  assign cznC = ctrl.cznFromDec ? (regA == '0)             : borrowAB;
  assign cznZ = ctrl.cznFromDec ? (decValue == '0)         : eqAB;
  assign cznN = ctrl.cznFromDec ? decValue[DATA_W-1]       : diffAB[DATA_W-1];

  always_comb begin
    flagBase = flagReg;
    if (ctrl.cznUpdate) begin
      flagBase[FLAG_C] = cznC;
      flagBase[FLAG_Z] = cznZ;
      flagBase[FLAG_N] = cznN;
    end
  end

  assign flagNext = applyBit(flagBase, ctrl.bitWrite & ~ctrl.bitToTest, sel, ctrl.bitValue);
  assign testNext = applyBit(testReg,  ctrl.bitWrite &  ctrl.bitToTest, sel, ctrl.bitValue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= '0;
      testReg <= '0;
    end else begin
      flagReg <= flagNext;
      testReg <= testNext;
    end
  end

  assert_flag_bit_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.bitWrite && !ctrl.bitToTest) |=> flagReg[$past(sel)] == $past(ctrl.bitValue));

  assert_test_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.bitWrite && ctrl.bitToTest) |=> $stable(testReg));

  assert_cmp_borrow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cznUpdate && !ctrl.cznFromDec) |=> flagReg[FLAG_C] == ($past(regA) < $past(regB)));

  assert_sector_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (taken && !ctrl.globalTgt) |-> pcNext[PC_W-1:DATA_W] == pcIn[PC_W-1:DATA_W]);

  assert_flags_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.bitWrite && !ctrl.cznUpdate) |=> $stable(flagReg));

  assert_dec_untaken_R5: assert property (@(posedge clk) disable iff (!rstN)
    decWrite |-> (ctrl.cond == COND_ZERO) && ((regA == '0) == ctrl.invert));

endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 24,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int HI_W  = PC_W - DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opcode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] target,
  input  logic [HI_W-1:0]   targetHigh,
  input  logic [PC_W-1:0]   pcIn,
  output logic              taken,
  output logic [PC_W-1:0]   pcNext,
  output logic              decWrite,
  output logic [DATA_W-1:0] decValue,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] testBits
);

  ctrl_t ctrl;

  bfu_ctrl ctrl_i (
    .opValid (opValid),
    .opcode  (opcode),
    .ctrl    (ctrl)
  );

  bfu_datapath #(.DATA_W(DATA_W), .PC_W(PC_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .sel        (sel),
    .regA       (regA),
    .regB       (regB),
    .target     (target),
    .targetHigh (targetHigh),
    .pcIn       (pcIn),
    .taken      (taken),
    .pcNext     (pcNext),
    .decWrite   (decWrite),
    .decValue   (decValue),
    .flagReg    (flags),
    .testReg    (testBits)
  );

endmodule

// File: tb/bfu_top_tb_top.sv
`timescale 1ns/1ps
module bfu_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [7:0]  opcode;
  logic [3:0]  sel;
  logic [15:0] regA, regB, target;
  logic [7:0]  targetHigh;
  logic [23:0] pcIn;
  logic        taken, decWrite;
  logic [23:0] pcNext;
  logic [15:0] decValue, flags, testBits;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] flagM = '0;
  logic [15:0] testM = '0;
  string       regTag = "R1";

  always #2.5 clk = ~clk;

  bfu_top dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode), .sel(sel),
    .regA(regA), .regB(regB), .target(target), .targetHigh(targetHigh),
    .pcIn(pcIn), .taken(taken), .pcNext(pcNext), .decWrite(decWrite),
    .decValue(decValue), .flags(flags), .testBits(testBits)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string opTag(logic v, logic [7:0] op);
    if (!v) return "R1";
    if (op >= 8'h80 && op <= 8'h83) return "R4";
    if (op == 8'h84 || op == 8'h85) return "R5";
    if (op >= 8'h86 && op <= 8'h89) return "R6";
    if (op == 8'hC0) return "R8";
    if (op == 8'hC1) return "R9";
    return "R10";
  endfunction

  task automatic step(logic v, logic [7:0] op, logic [3:0] s, logic [15:0] a,
                      logic [15:0] b, logic [15:0] t, logic [7:0] h, logic [23:0] pc);
    logic expT, isCond, expDw;
    int   len;
    logic [23:0] expPc;
    logic [15:0] d;
    string tg;
    opValid = v; opcode = op; sel = s; regA = a; regB = b;
    target = t; targetHigh = h; pcIn = pc;
    #1;
    isCond = v && op >= 8'h80 && op <= 8'h89;
    expT = 1'b0;
    if (v) begin
      case (op)
        8'h80: expT = flagM[s];
        8'h81: expT = !flagM[s];
        8'h82: expT = testM[s];
        8'h83: expT = !testM[s];
        8'h84: expT = (a == 0);
        8'h85: expT = (a != 0);
        8'h86: expT = (a == b);
        8'h87: expT = (a != b);
        8'h88: expT = (a > b);
        8'h89: expT = (a >= b);
        8'hC0, 8'hC1: expT = 1'b1;
        default: expT = 1'b0;
      endcase
    end
    len = !v ? 0 : (op == 8'hC1) ? 3 : (isCond || op == 8'hC0) ? 2 : 1;
    if (expT) expPc = (op == 8'hC1) ? {h, t} : {pc[23:16], t};
    else      expPc = pc + 24'(len);
    expDw = v && (op == 8'h84 || op == 8'h85) && !expT;
    tg = opTag(v, op);
    check(tg, "taken", 32'(taken), 32'(expT));
    check(expT ? (op == 8'hC1 ? "R9" : "R8") : (v ? "R10" : "R1"), "pcNext", 32'(pcNext), 32'(expPc));
    check("R5", "decWrite", 32'(decWrite), 32'(expDw));
    if (expDw) check("R5", "decValue", 32'(decValue), 32'(16'(a - 16'd1)));
    check(regTag, "flags", 32'(flags), 32'(flagM));
    check(regTag, "testBits", 32'(testBits), 32'(testM));
    @(posedge clk);
    regTag = "R10";
    if (v) begin
      case (op)
        8'hE0: begin flagM[s] = 1'b1; regTag = "R2"; end
        8'hE1: begin flagM[s] = 1'b0; regTag = "R2"; end
        8'hE2: begin testM[s] = 1'b1; regTag = "R3"; end
        8'hE3: begin testM[s] = 1'b0; regTag = "R3"; end
        8'h84, 8'h85: begin
          d = a - 16'd1;
          flagM[0] = (a == 0); flagM[1] = (d == 0); flagM[2] = d[15];
          regTag = "R7";
        end
        8'h86, 8'h87, 8'h88, 8'h89: begin
          d = a - b;
          flagM[0] = (a < b); flagM[1] = (d == 0); flagM[2] = d[15];
          regTag = "R7";
        end
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  function automatic logic [15:0] pickVal();
    case ($urandom_range(0, 5))
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h8000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    logic [7:0] ops [19] = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86,
                            8'h87, 8'h88, 8'h89, 8'hC0, 8'hC1, 8'hE0, 8'hE1,
                            8'hE2, 8'hE3, 8'h00, 8'h45, 8'hFF};
    rstN = 1'b0; opValid = 1'b0; opcode = '0; sel = '0; regA = '0; regB = '0;
    target = '0; targetHigh = '0; pcIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with no instruction
    step(0, 8'h80, 0, 0, 0, 16'h1234, 8'h00, 24'h345678);
    rstN = 1'b1;
    step(0, 8'hC1, 5, 0, 0, 16'h1111, 8'h22, 24'h010203);
    // R2 / R4: flag set, then tested both ways
    step(1, 8'hE0, 4'd3, 0, 0, 0, 0, 24'h000100);
    step(1, 8'h80, 4'd3, 0, 0, 16'hABCD, 8'h00, 24'h120010);
    step(1, 8'h81, 4'd3, 0, 0, 16'hABCD, 8'h00, 24'h120010);
    step(1, 8'hE1, 4'd3, 0, 0, 0, 0, 24'h000100);
    step(1, 8'h81, 4'd3, 0, 0, 16'h0042, 8'h00, 24'h7F0000);
    // R3 / R4: top test bit
    step(1, 8'hE2, 4'd15, 0, 0, 0, 0, 24'h000200);
    step(1, 8'h82, 4'd15, 0, 0, 16'h5555, 8'h00, 24'hA0FFF0);
    step(1, 8'h83, 4'd15, 0, 0, 16'h5555, 8'h00, 24'hA0FFF0);
    step(1, 8'hE3, 4'd15, 0, 0, 0, 0, 24'h000200);
    // R5 / R7: count-down edges
    step(1, 8'h84, 0, 16'h0000, 0, 16'h0300, 0, 24'h050000);
    step(1, 8'h84, 0, 16'h0001, 0, 16'h0300, 0, 24'h050000);
    step(1, 8'h85, 0, 16'h0000, 0, 16'h0300, 0, 24'h050000);
    step(1, 8'h85, 0, 16'h0007, 0, 16'h0300, 0, 24'h050000);
    // R6 / R7: unsigned compare, equal operands
    step(1, 8'h88, 0, 16'hFFFF, 16'h0001, 16'h0400, 0, 24'h060000);
    step(1, 8'h89, 0, 16'h0001, 16'hFFFF, 16'h0400, 0, 24'h060000);
    step(1, 8'h86, 0, 16'h8000, 16'h8000, 16'h0400, 0, 24'h060000);
    step(1, 8'h87, 0, 16'h8000, 16'h8000, 16'h0400, 0, 24'h060000);
    step(1, 8'h89, 0, 16'h1234, 16'h1234, 16'h0400, 0, 24'h060000);
    // R10: fall-through carry into sector bits and full wrap
    step(1, 8'h88, 0, 16'h0001, 16'h0002, 16'h0400, 0, 24'h12FFFF);
    step(1, 8'h86, 0, 16'h0001, 16'h0002, 16'h0400, 0, 24'hFFFFFE);
    step(1, 8'hE0, 4'd9, 0, 0, 0, 0, 24'hFFFFFF);
    step(1, 8'h45, 4'd9, 16'h1, 16'h1, 0, 0, 24'h00FFFF);
    // R8 / R9: jumps
    step(1, 8'hC0, 0, 0, 0, 16'hBEEF, 8'h77, 24'h3C1234);
    step(1, 8'hC1, 0, 0, 0, 16'hBEEF, 8'h77, 24'h3C1234);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [15:0] b;
      logic [23:0] pc;
      a = pickVal();
      b = ($urandom_range(0, 3) == 0) ? a : pickVal();
      pc = 24'($urandom);
      if ($urandom_range(0, 7) == 0) pc[15:0] = 16'hFFFE + 16'($urandom_range(0, 1));
      step($urandom_range(0, 9) != 0, ops[$urandom_range(0, 18)], 4'($urandom),
           a, b, 16'($urandom), 8'($urandom), pc);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule